// File: doc/BRIEF.md
# Video frame capture writer

This block sits behind a raster timing generator and a set of colour digitizers. It stores one video frame into a word-addressed buffer. The timing generator supplies horizontal and vertical counts that start at the sync pulse. The block subtracts the sync and back-porch widths from those counts to get an image row and column. It decides whether the pair lies inside the visible window and forms a linear buffer address. Each visible pixel is written as one 24-bit word through a synchronous single-port write interface: a write enable, an address and write data.

Colour samples arrive a fixed, parameterised number of clocks after the counts that produced them. The block delays the counts by the same amount, so each address is paired with its own pixel. Capture is armed by an enable input. A frame is only ever captured whole, from its first visible pixel to its last. A pulse marks the write that closes each row, and another marks the write that closes the frame.

Top module: `frame_capture_writer`

## Requirements
- R1: While the synchronous active-high reset is high, mem_we, mem_addr, mem_wdata, line_done and frame_done are all zero one clock later.
- R2: mem_we is low for every count pair outside the visible window. The window is row = vcount - (V_SYNC + V_BACK) in 0..V_VIS-1 and col = hcount - (H_SYNC + H_BACK) in 0..H_VIS-1. mem_we is also low for every pixel of a frame that is not being captured.
- R3: The address of a write is BASE + row * STRIDE + col, with STRIDE the line pitch in words.
- R4: The write word is red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: Counts are delayed by LAT clocks to match the pixel latency. A pixel presented together with the counts from LAT clocks earlier appears on the write port one clock after it is presented.
- R6: Capture starts only at the pixel with row 0, col 0, if capture_en is high in that pixel's cycle. Raising capture_en in the middle of a frame causes no write until the next frame starts.
- R7: Once started, a capture writes every visible pixel of that frame even if capture_en drops. After the last pixel no further writes occur unless capture_en is high at the next frame start.
- R8: line_done is a one-clock pulse high together with the write of col H_VIS-1 of each captured row.
- R9: frame_done is a one-clock pulse high together with the write of row V_VIS-1, col H_VIS-1.
- R10: mem_addr and mem_wdata keep their last written values while mem_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Arms capture of the next whole frame |
| h_cnt | input | CW | Horizontal count, zero at start of sync |
| v_cnt | input | CW | Vertical count, zero at start of sync |
| red | input | 8 | Red sample, LAT clocks after its counts |
| green | input | 8 | Green sample |
| blue | input | 8 | Blue sample |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | AW | Buffer word address |
| mem_wdata | output | 24 | Packed pixel word |
| line_done | output | 1 | Pulse with the last write of a row |
| frame_done | output | 1 | Pulse with the last write of a frame |

## Verification
Some properties are checked on every clock by the assertions. Writes always land inside the frame's address range, and back-to-back writes step the address by one. line_done and frame_done only accompany a write, and frame_done carries the last pixel's address and is followed by a blanking cycle. Other behaviour needs the bench's reference model running a shrunken raster over several frames. That covers arming in mid-frame, finishing a frame after the enable drops, the exact byte packing under the pixel latency, the hold of address and data in blanking, and the number of writes per frame.

// File: rtl/frame_capture_writer.sv
module frame_capture_writer #(
  parameter int CW     = 10,
  parameter int H_SYNC = 96,
  parameter int H_BACK = 48,
  parameter int H_VIS  = 640,
  parameter int V_SYNC = 2,
  parameter int V_BACK = 33,
  parameter int V_VIS  = 480,
  parameter int STRIDE = 640,
  parameter int BASE   = 52,
  parameter int AW     = 20,
  parameter int LAT    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture_en,
  input  logic [CW-1:0] h_cnt,
  input  logic [CW-1:0] v_cnt,
  input  logic [7:0]    red,
  input  logic [7:0]    green,
  input  logic [7:0]    blue,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [23:0]   mem_wdata,
  output logic          line_done,
  output logic          frame_done
);
  localparam int H_OFF = H_SYNC + H_BACK;
  localparam int V_OFF = V_SYNC + V_BACK;
  localparam int LAST_ADDR = BASE + (V_VIS - 1) * STRIDE + H_VIS - 1;

  logic [LAT-1:0][CW-1:0] hd, vd;
  logic [CW-1:0] ha, va, row, col;
  logic vis, first, last_col, last_pix, wr, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hd <= '0;
      vd <= '0;
    end else begin
      hd[0] <= h_cnt;
      vd[0] <= v_cnt;
      for (int i = 1; i < LAT; i++) begin
        hd[i] <= hd[i-1];
        vd[i] <= vd[i-1];
      end
    end
  end

  assign ha  = hd[LAT-1];
  assign va  = vd[LAT-1];
  assign row = va - CW'(V_OFF);
  assign col = ha - CW'(H_OFF);

  assign vis = (32'(ha) >= H_OFF) && (32'(ha) < H_OFF + H_VIS) &&
               (32'(va) >= V_OFF) && (32'(va) < V_OFF + V_VIS);
  assign first    = vis && (row == '0) && (col == '0);
  assign last_col = vis && (col == CW'(H_VIS - 1));
  assign last_pix = last_col && (row == CW'(V_VIS - 1));
  assign wr       = vis && (active || (first && capture_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      line_done  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      mem_we     <= wr;
      line_done  <= wr && last_col;
      frame_done <= wr && last_pix;
      if (wr) begin
        mem_addr  <= AW'(BASE) + AW'(row) * AW'(STRIDE) + AW'(col);
        mem_wdata <= {red, green, blue};
      end
      if (wr && last_pix)
        active <= 1'b0;
      else if (first && capture_en)
        active <= 1'b1;
    end
  end

  assert_addr_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= AW'(BASE)) && (mem_addr <= AW'(LAST_ADDR)));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  assert_line_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    line_done |-> mem_we);

  assert_frame_end_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (mem_we && line_done && mem_addr == AW'(LAST_ADDR)));

  assert_blank_after_frame_R2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !mem_we && !frame_done);
endmodule

// File: tb/sim_frame_capture_writer.sv
module sim_frame_capture_writer;
  localparam int CW = 6, H_SYNC = 3, H_BACK = 2, H_VIS = 8, H_FRONT = 3;
  localparam int V_SYNC = 1, V_BACK = 2, V_VIS = 4, V_FRONT = 2;
  localparam int STRIDE = 10, BASE = 52, AW = 12, LAT = 2;
  localparam int H_TOT = H_SYNC + H_BACK + H_VIS + H_FRONT;
  localparam int V_TOT = V_SYNC + V_BACK + V_VIS + V_FRONT;
  localparam int FRAME = H_TOT * V_TOT;

  logic clk = 1'b0, rst = 1'b1, capture_en = 1'b0;
  logic [CW-1:0] h_cnt = '0, v_cnt = '0;
  logic [7:0] red = '0, green = '0, blue = '0;
  logic mem_we, line_done, frame_done;
  logic [AW-1:0] mem_addr;
  logic [23:0] mem_wdata;

  int vectors = 0, miscompares = 0;
  int hc = 0, vc = 0, cyc = 0;
  int hh[LAT+1], vv[LAT+1];
  bit act = 0, e_we = 0, e_ld = 0, e_fd = 0;
  int e_addr = 0, e_data = 0;
  int n_writes = 0, n_frames = 0, early_writes = 0, first_addr = -1, last_addr = -1;

  always #4 clk = ~clk;

  frame_capture_writer #(.CW(CW), .H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_VIS(H_VIS),
    .V_SYNC(V_SYNC), .V_BACK(V_BACK), .V_VIS(V_VIS), .STRIDE(STRIDE), .BASE(BASE),
    .AW(AW), .LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .capture_en(capture_en), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .red(red), .green(green), .blue(blue), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .line_done(line_done), .frame_done(frame_done));

  task automatic check(string tag, int act_v, int exp_v);
    vectors++;
    if (act_v != exp_v) begin
      miscompares++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act_v, exp_v);
    end
  endtask

  // One clock: compare the previous prediction, drive, predict the next edge.
  task automatic step(bit en, bit in_rst, bit do_chk);
    int ah, av, row, col, r, g, b;
    bit vis, first, wr;
    @(negedge clk);
    if (do_chk) begin
      check("R2 R6 R7 mem_we", int'(mem_we), int'(e_we));
      check("R3 R5 R10 mem_addr", int'(mem_addr), e_addr);
      check("R4 R5 R10 mem_wdata", int'(mem_wdata), e_data);
      check("R8 line_done", int'(line_done), int'(e_ld));
      check("R9 frame_done", int'(frame_done), int'(e_fd));
      if (mem_we) begin
        n_writes++;
        if (first_addr < 0) first_addr = int'(mem_addr);
        last_addr = int'(mem_addr);
      end
      if (frame_done) n_frames++;
      if (mem_we && cyc <= 2 * FRAME) early_writes++;
    end
    rst = in_rst;
    capture_en = en;
    h_cnt = CW'(in_rst ? 0 : hc);
    v_cnt = CW'(in_rst ? 0 : vc);
    for (int k = LAT; k > 0; k--) begin
      hh[k] = hh[k-1];
      vv[k] = vv[k-1];
    end
    hh[0] = int'(h_cnt);
    vv[0] = int'(v_cnt);
    ah = hh[LAT];
    av = vv[LAT];
    r = (ah * 7 + av) & 255;
    g = ((av * 13) ^ ah) & 255;
    b = (ah + av * 3 + 165) & 255;
    red = 8'(r);
    green = 8'(g);
    blue = 8'(b);
    if (in_rst) begin
      act = 0; e_we = 0; e_ld = 0; e_fd = 0; e_addr = 0; e_data = 0;
      for (int k = 0; k <= LAT; k++) begin
        hh[k] = 0;
        vv[k] = 0;
      end
    end else begin
      row = av - (V_SYNC + V_BACK);
      col = ah - (H_SYNC + H_BACK);
      vis = row >= 0 && row < V_VIS && col >= 0 && col < H_VIS;
      first = vis && row == 0 && col == 0;
      wr = vis && (act || (first && en));
      e_we = wr;
      e_ld = wr && col == H_VIS - 1;
      e_fd = e_ld && row == V_VIS - 1;
      if (wr) begin
        e_addr = BASE + row * STRIDE + col;
        e_data = (r << 16) | (g << 8) | b;
      end
      if (e_fd) act = 0;
      else if (first && en) act = 1;
      cyc++;
      hc++;
      if (hc == H_TOT) begin
        hc = 0;
        vc = (vc + 1) % V_TOT;
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit en;
    for (int k = 0; k <= LAT; k++) begin
      hh[k] = 0;
      vv[k] = 0;
    end
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, i > 0);
    // R1: outputs still zero right after reset
    check("R1 reset we", int'(mem_we), 0);
    check("R1 reset addr", int'(mem_addr), 0);
    check("R1 reset data", int'(mem_wdata), 0);
    // Frame 0 disabled (R2); enable raised mid frame 1 (R6);
    // frames 2 and 3 captured, enable dropped mid frame 3 (R7); frame 4 idle; frame 5 captured.
    for (int i = 0; i < 6 * FRAME + 12; i++) begin
      en = (i >= FRAME + 5 * H_TOT && i < 3 * FRAME + 70) || (i >= 5 * FRAME);
      step(en, 1'b0, 1'b1);
    end
    check("R6 no write before armed frame", early_writes, 0);
    check("R2 R7 total visible writes", n_writes, 3 * H_VIS * V_VIS);
    check("R9 frame_done count", n_frames, 3);
    check("R3 first captured address", first_addr, BASE);
    check("R3 last captured address", last_addr, BASE + (V_VIS - 1) * STRIDE + H_VIS - 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule